// File: doc/BRIEF.md
# Data bus line tester

This block is a hardware self-test engine for the data lines of a memory bus. It drives a plain synchronous memory port and, after a start pulse, runs a fixed series of stripe-shaped test words over a single target word. Each stripe word makes every pair of data lines take opposite values at least once, whatever the board routing. Each word is written to the target. A decoy word is then written to the next word address, so that a floating bus holds the decoy and not the test word. The target is then read exactly once.

The captured read value is compared with the test word. A mismatch makes the run fail, but the run still applies every remaining word. Only the first mismatch is kept for software: its pattern index, the expected and observed words, and the target address. Read data may return after any number of cycles. The engine moves on only when the read-valid strobe marks the reply.

Top module: `dbus_line_tester`

## Requirements
- R1: After reset, busy, done, pass, fail and mem_req are low, and all failure records are zero.
- R2: With a 64-bit bus, the twelve test words are used in this order: AAAA..AA, CCCC..CC, F0F0..F0, FF00..FF00, FFFF0000FFFF0000, FFFFFFFF00000000, 00000000FFFFFFFF, 0000FFFF0000FFFF, 00FF00FF..00FF, 0F0F..0F, 3333..33, 5555..55. Word k for k below log2(width) has bit i equal to bit k of i. Each later word is the complement of the earlier words, taken in reverse order.
- R3: For each word, the engine issues three one-cycle accesses on back-to-back cycles. First it writes the word to the target. Then it writes the decoy (0x0123456789ABCDEF by default) to target+1, which wraps within the address width. Then it issues one read of the target. A run therefore makes exactly 3 x number-of-words accesses.
- R4: The read data is taken only in a cycle where mem_rvalid is high and the engine is waiting for its read reply. Strobes at any other time are ignored, and a reply arriving one or more cycles after the request is accepted.
- R5: A mismatch sets fail. fail stays set until the next accepted start, and the remaining words are still applied.
- R6: Only the first mismatch is recorded: fail_idx (0-based word index), fail_exp (the word written), fail_obs (the word read) and fail_addr (the target).
- R7: busy is high from the cycle after an accepted start until done. done is a single-cycle pulse that comes in the same cycle busy falls. pass goes high with done when no mismatch occurred, and pass and fail are never high together.
- R8: A start while busy is ignored. An accepted start latches base_addr as the target and clears pass, fail and the failure records.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run when idle |
| base_addr | input | ADDR_W | Target word address, latched at start |
| mem_req | output | 1 | Memory access request, one cycle per access |
| mem_we | output | 1 | Write when high, read when low |
| mem_addr | output | ADDR_W | Word address |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid with mem_rvalid |
| mem_rvalid | input | 1 | Read reply strobe |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | Last run saw no mismatch |
| fail | output | 1 | Sticky mismatch flag |
| fail_idx | output | IDX_W | Index of first failing word |
| fail_exp | output | DATA_W | Expected word of first failure |
| fail_obs | output | DATA_W | Observed word of first failure |
| fail_addr | output | ADDR_W | Target address of first failure |

## Verification
The bench builds the block with a 64-bit data bus, giving the full twelve-word list, and an 8-bit word address. With the narrow address, a target at the top address puts the decoy write at address zero, which covers the wrap case. The bench memory model returns reads after 1 to 5 cycles and can send spurious strobes during write cycles. It can also force one data line stuck at 0 or 1, or act as an open bus that echoes the last written word. Under these faults, the first failing index, the expected word and the observed word can all be predicted from the word list.

// File: rtl/dbus_line_tester.sv
module dbus_line_tester #(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 16,
  parameter logic [DATA_W-1:0] DECOY = DATA_W'(64'h0123_4567_89AB_CDEF),
  localparam int STRIPES = $clog2(DATA_W),
  localparam int NUM_PAT = 2 * STRIPES,
  localparam int IDX_W = $clog2(NUM_PAT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_addr,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_rvalid,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic              fail,
  output logic [IDX_W-1:0]  fail_idx,
  output logic [DATA_W-1:0] fail_exp,
  output logic [DATA_W-1:0] fail_obs,
  output logic [ADDR_W-1:0] fail_addr
);

  typedef enum logic [2:0] {S_IDLE, S_WPAT, S_WDEC, S_RREQ, S_RWAIT} state_t;

  state_t            state;
  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-1:0] tgt;
  logic [DATA_W-1:0] word;
  logic              miss;
  logic              last;

  function automatic logic [DATA_W-1:0] stripe(input int k);
    logic [DATA_W-1:0] s;
    for (int i = 0; i < DATA_W; i++) s[i] = ((i >> k) & 1) == 1;
    return s;
  endfunction

  assign word = (int'(idx) < STRIPES) ? stripe(int'(idx)) : ~stripe(NUM_PAT - 1 - int'(idx));
  assign miss = mem_rdata != word;
  assign last = idx == IDX_W'(NUM_PAT - 1);

  assign busy      = state != S_IDLE;
  assign mem_req   = state == S_WPAT || state == S_WDEC || state == S_RREQ;
  assign mem_we    = state == S_WPAT || state == S_WDEC;
  assign mem_addr  = (state == S_WDEC) ? tgt + ADDR_W'(1) : tgt;
  assign mem_wdata = (state == S_WDEC) ? DECOY : word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      idx       <= '0;
      tgt       <= '0;
      done      <= 1'b0;
      pass      <= 1'b0;
      fail      <= 1'b0;
      fail_idx  <= '0;
      fail_exp  <= '0;
      fail_obs  <= '0;
      fail_addr <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          tgt       <= base_addr;
          idx       <= '0;
          pass      <= 1'b0;
          fail      <= 1'b0;
          fail_idx  <= '0;
          fail_exp  <= '0;
          fail_obs  <= '0;
          fail_addr <= '0;
          state     <= S_WPAT;
        end
        S_WPAT: state <= S_WDEC;
        S_WDEC: state <= S_RREQ;
        S_RREQ: state <= S_RWAIT;
        S_RWAIT: if (mem_rvalid) begin
          if (miss) begin
            fail <= 1'b1;
            if (!fail) begin
              fail_idx  <= idx;
              fail_exp  <= word;
              fail_obs  <= mem_rdata;
              fail_addr <= tgt;
            end
          end
          if (last) begin
            state <= S_IDLE;
            done  <= 1'b1;
            pass  <= !(fail || miss);
          end else begin
            idx   <= idx + IDX_W'(1);
            state <= S_WPAT;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

module dbus_line_tester_chk #(
  parameter int DATA_W = 64,
  parameter int IDX_W = 4,
  parameter logic [DATA_W-1:0] DECOY = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req,
  input logic              mem_we,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              busy,
  input logic              done,
  input logic              pass,
  input logic              fail,
  input logic [IDX_W-1:0]  fail_idx
);

  // R3
  decoy_after_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_wdata != DECOY) |=> (mem_req && mem_we && mem_wdata == DECOY));

  // R3
  read_after_decoy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_wdata == DECOY) |=> (mem_req && !mem_we));

  // R7
  req_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R7
  pass_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass && fail));

  // R5
  fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && fail) |=> fail);

  // R6
  first_idx_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && fail) |=> $stable(fail_idx));

endmodule

bind dbus_line_tester dbus_line_tester_chk #(
  .DATA_W(DATA_W), .IDX_W(IDX_W), .DECOY(DECOY)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
  .mem_wdata(mem_wdata), .busy(busy), .done(done), .pass(pass),
  .fail(fail), .fail_idx(fail_idx)
);

// File: tb/dbus_line_tester_tb.sv
`timescale 1ns/1ps
module dbus_line_tester_tb;
  localparam int DW = 64;
  localparam int AW = 8;
  localparam logic [63:0] DEC = 64'h0123_4567_89AB_CDEF;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [AW-1:0] base_addr = '0;
  logic mem_req, mem_we, mem_rvalid, busy, done, pass, fail;
  logic [AW-1:0] mem_addr, fail_addr;
  logic [DW-1:0] mem_wdata, mem_rdata, fail_exp, fail_obs;
  logic [3:0] fail_idx;

  always #4 clk = ~clk;

  dbus_line_tester #(.DATA_W(DW), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid), .busy(busy), .done(done),
    .pass(pass), .fail(fail), .fail_idx(fail_idx), .fail_exp(fail_exp),
    .fail_obs(fail_obs), .fail_addr(fail_addr));

  int n_chk = 0, n_err = 0;
  int lat = 1, mode = 0, bitn = 0;
  bit junk = 0;
  logic [63:0] mem [256];
  logic [63:0] last_wr = '0, rd_q = '0;
  logic pend = 0;
  int cnt = 0;
  int n_acc = 0, n_done = 0;
  bit acc_we [64];
  logic [AW-1:0] acc_addr [64];
  logic [63:0] acc_data [64];

  function automatic logic [63:0] exp_pat(input int k);
    case (k)
      0: return 64'hAAAAAAAAAAAAAAAA;  1: return 64'hCCCCCCCCCCCCCCCC;
      2: return 64'hF0F0F0F0F0F0F0F0;  3: return 64'hFF00FF00FF00FF00;
      4: return 64'hFFFF0000FFFF0000;  5: return 64'hFFFFFFFF00000000;
      6: return 64'h00000000FFFFFFFF;  7: return 64'h0000FFFF0000FFFF;
      8: return 64'h00FF00FF00FF00FF;  9: return 64'h0F0F0F0F0F0F0F0F;
      10: return 64'h3333333333333333; default: return 64'h5555555555555555;
    endcase
  endfunction

  function automatic logic [63:0] fault(input logic [63:0] v);
    case (mode)
      1: return v & ~(64'd1 << bitn);
      2: return last_wr;
      3: return v | (64'd1 << bitn);
      default: return v;
    endcase
  endfunction

  function automatic int first_fail();
    for (int k = 0; k < 12; k++)
      if (fault(exp_pat(k)) != exp_pat(k) || (mode == 2 && exp_pat(k) != DEC)) return k;
    return -1;
  endfunction

  assign mem_rvalid = (pend && cnt == 0) || (junk && mem_req && mem_we);
  assign mem_rdata  = (pend && cnt == 0) ? rd_q : 64'hDEAD_BEEF_0BAD_F00D;

  always @(posedge clk) begin
    if (mem_req && mem_we) begin
      mem[mem_addr] <= mem_wdata;
      last_wr <= mem_wdata;
    end
    if (mem_req && !mem_we) begin
      pend <= 1'b1;
      cnt  <= lat - 1;
      rd_q <= (mode == 2) ? last_wr : fault(mem[mem_addr]);
    end else if (pend) begin
      if (cnt == 0) pend <= 1'b0;
      else cnt <= cnt - 1;
    end
    if (rst_n && mem_req) begin
      if (n_acc < 64) begin
        acc_we[n_acc] = mem_we; acc_addr[n_acc] = mem_addr; acc_data[n_acc] = mem_wdata;
      end
      n_acc = n_acc + 1;
    end
    if (rst_n && done) n_done = n_done + 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  task automatic run(input logic [AW-1:0] b, input int l, input int m, input int bn,
                     input bit j, input bit dup);
    int ff, bad, wd;
    logic [AW-1:0] nb;
    lat = l; mode = m; bitn = bn; junk = j;
    @(negedge clk);
    n_acc = 0; n_done = 0;
    base_addr = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    base_addr = ~b;
    chk(busy == 1'b1, "R7", "busy after start", 64'(busy), 64'd1);
    wd = 0;
    while (!done && wd < 2000) begin
      @(negedge clk);
      wd++;
      if (dup && wd == 10) start = 1'b1;
      else start = 1'b0;
    end
    start = 1'b0;
    chk(done == 1'b1, "R7", "done reached", 64'(done), 64'd1);
    chk(busy == 1'b0, "R7", "busy low at done", 64'(busy), 64'd0);
    ff = first_fail();
    chk(fail == (ff >= 0), "R5", "fail flag", 64'(fail), 64'(ff >= 0));
    chk(pass == (ff < 0), "R7", "pass flag", 64'(pass), 64'(ff < 0));
    if (ff >= 0) begin
      chk(fail_idx == 4'(ff), "R6", "first index", 64'(fail_idx), 64'(ff));
      chk(fail_exp == exp_pat(ff), "R6", "expected word", fail_exp, exp_pat(ff));
      chk(fail_obs == ((mode == 2) ? DEC : fault(exp_pat(ff))), "R6", "observed word",
          fail_obs, (mode == 2) ? DEC : fault(exp_pat(ff)));
      chk(fail_addr == b, "R6", "target address", 64'(fail_addr), 64'(b));
    end
    chk(n_acc == 36, "R5", "access count", 64'(n_acc), 64'd36);
    bad = 0;
    nb = b + 8'd1;
    for (int k = 0; k < 12 && 3 * k + 2 < n_acc; k++) begin
      if (!acc_we[3*k] || acc_addr[3*k] != b || acc_data[3*k] != exp_pat(k)) bad++;
      if (!acc_we[3*k+1] || acc_addr[3*k+1] != nb || acc_data[3*k+1] != DEC) bad++;
      if (acc_we[3*k+2] || acc_addr[3*k+2] != b) bad++;
    end
    chk(bad == 0, "R2", "access sequence", 64'(bad), 64'd0);
    chk(mem[b] == exp_pat(11) && mem[nb] == DEC, "R3", "target and decoy contents",
        mem[nb], DEC);
    @(negedge clk);
    chk(done == 1'b0 && n_done == 1, "R7", "single done pulse", 64'(n_done), 64'd1);
  endtask

  initial begin
    #(8 * 190000);
    n_err++;
    $display("FAIL watchdog expired: actual=%0d expected=%0d", 1, 0);
    finish_up();
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !pass && !fail && !mem_req, "R1", "idle flags", 64'({busy, done, pass, fail, mem_req}), 64'd0);
    chk(fail_idx == 0 && fail_exp == 0 && fail_obs == 0 && fail_addr == 0, "R1", "records zero",
        fail_obs, 64'd0);
    rst_n = 1'b1;
    run(8'h00, 1, 0, 0, 0, 0);
    run(8'hFF, 3, 0, 0, 1, 0);   // R3 decoy wraps, R4 spurious strobes
    run(8'h10, 5, 1, 0, 0, 0);   // R5 stuck-0 on bit 0 first fails at index 6
    run(8'h20, 2, 1, 5, 1, 0);   // R6 stuck-0 on bit 5 fails at index 0
    run(8'h30, 4, 3, 63, 0, 0);  // stuck-1 on top bit
    run(8'h40, 1, 2, 0, 0, 0);   // open bus echoes decoy
    run(8'h55, 2, 0, 0, 0, 1);   // R8 start while busy ignored, fail cleared
    for (int r = 0; r < 8; r++)
      run(8'($urandom_range(0, 255)), int'($urandom_range(1, 5)), int'($urandom_range(0, 3)),
          int'($urandom_range(0, 63)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    run(8'h77, 1, 0, 0, 0, 0);   // R8 final clean run after a fault
    finish_up();
  end
endmodule